// File: doc/BRIEF.md
# Active-Low Network Interrupt Aggregator

This block gathers per-port interrupt requests from a small number of network module slots and keeps them in two 16-bit status words. In each word a bit reads 0 while a port has an interrupt pending and 1 when it is idle. Slot-side logic raises or drops a request with a one-cycle pulse that carries a slot number and a port number. A lookup gives each slot a status word and a base bit, and the port number is added to that base bit.

Whenever either status word is not all ones, the block drives a single combined interrupt line to the processor. The processor finds the source by reading the two words through a small combinational read port. That port answers at two fixed addresses. The status words change only through slot-side pulses. The read port has no path that writes them.

Top module: `netirq_agg`

## Requirements
- R1: Out of reset both status words are 0xFFFF and `irqOut` is 0.
- R2: A raise pulse (`setValid`) for slot s and port p clears bit p of status word s (slot 0 uses word 0, slot 1 uses word 1, base bit 0 for both) at the next clock edge.
- R3: A drop pulse (`clrValid`) for slot s and port p sets that same bit back to 1 at the next clock edge.
- R4: When a raise and a drop name the same bit in the same cycle, the bit becomes 0.
- R5: When a raise and a drop name different bits in the same cycle, both take effect at the same edge.
- R6: A pulse that names slot 2 or above changes no status bit.
- R7: A pulse whose bit position (base bit plus port) is 16 or more changes no status bit.
- R8: `irqOut` is registered. One clock after a status word leaves 0xFFFF it is 1. One clock after both words are back at 0xFFFF it is 0.
- R9: `rdData` shows word 0 while `rdAddr` is 0x26 and word 1 while `rdAddr` is 0x28, combinationally. Any other address reads 0x0000.
- R10: In a cycle with no valid pulse, both status words keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| setValid | input | 1 | Raise pulse: an interrupt for the named port is pending |
| setSlot | input | 2 | Slot number of the raise pulse |
| setPort | input | 5 | Port number of the raise pulse |
| clrValid | input | 1 | Drop pulse: the named port's interrupt is gone |
| clrSlot | input | 2 | Slot number of the drop pulse |
| clrPort | input | 5 | Port number of the drop pulse |
| rdAddr | input | 8 | Read address for the status words |
| rdData | output | 16 | Selected status word, or 0x0000 for an unmapped address |
| irqOut | output | 1 | Combined interrupt, registered, active high |

## Verification
A raise and a drop can arrive in the same clock. They can name the same status bit, where the raise must win, or two different bits, possibly in different words, where both must land. The bench drives both pulse sets in one cycle, once for each case. After the edge it reads both words through the read port and compares them with a model that applies the drop first and the raise second. It also checks that the interrupt line follows the words of the previous cycle.

// File: rtl/netirq_pkg.sv
package netirq_pkg;
  localparam int NET_REGS = 2;
  localparam int STAT_W = 16;

  typedef logic [NET_REGS-1:0][STAT_W-1:0] regs_t;

  typedef struct packed {
    regs_t pullLow;
    regs_t releaseHigh;
  } strobe_t;

  // Slot to status word lookup
  function automatic int slotReg(int slot);
    return slot % NET_REGS;
  endfunction

  // Slot to base bit lookup (every slot starts at bit 0)
  function automatic int slotOffset(int slot);
    return (slot < 0) ? 0 : 0;
  endfunction
endpackage

// File: rtl/netirq_ctrl.sv
module netirq_ctrl
  import netirq_pkg::*;
#(
  parameter int NUM_SLOTS = 2,
  parameter int SLOT_W = 2,
  parameter int PORT_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setValid,
  input  logic [SLOT_W-1:0] setSlot,
  input  logic [PORT_W-1:0] setPort,
  input  logic              clrValid,
  input  logic [SLOT_W-1:0] clrSlot,
  input  logic [PORT_W-1:0] clrPort,
  output strobe_t           strobe
);

  function automatic regs_t decodeReq(logic v, logic [SLOT_W-1:0] s,
                                      logic [PORT_W-1:0] p);
    regs_t m;
    int pos;
    m = '0;
    if (v && (int'(s) < NUM_SLOTS)) begin
      pos = slotOffset(int'(s)) + int'(p);
      if (pos < STAT_W) begin
        for (int r = 0; r < NET_REGS; r++) begin
          if (r == slotReg(int'(s))) m[r] = STAT_W'(1) << pos;
        end
      end
    end
    return m;
  endfunction

  always_comb begin
    strobe.pullLow     = decodeReq(setValid, setSlot, setPort);
    strobe.releaseHigh = decodeReq(clrValid, clrSlot, clrPort);
  end

  // R6
  bad_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (setValid && int'(setSlot) >= NUM_SLOTS) |-> (strobe.pullLow == '0));

  // R7
  bad_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    (setValid && int'(setPort) >= STAT_W) |-> (strobe.pullLow == '0));

  // R2
  single_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(strobe.pullLow) <= 1);

endmodule

// File: rtl/netirq_dp.sv
module netirq_dp
  import netirq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BASE_ADDR = 'h26,
  parameter int ADDR_STRIDE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [STAT_W-1:0] rdData,
  output logic              irqOut
);

  regs_t statusQ;
  logic  irqQ;

  // The drop is applied first, then the raise, so a raise wins on a shared bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '1;
      irqQ    <= 1'b0;
    end else begin
      statusQ <= (statusQ | strobe.releaseHigh) & ~strobe.pullLow;
      irqQ    <= (statusQ != '1);
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NET_REGS; i++) begin
      if (rdAddr == ADDR_W'(BASE_ADDR + i * ADDR_STRIDE)) rdData = statusQ[i];
    end
  end

  assign irqOut = irqQ;

  // R2
  set_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pullLow != '0) |=> ((statusQ & $past(strobe.pullLow)) == '0));

  // R3
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.releaseHigh != '0) |=>
      ((statusQ & ($past(strobe.releaseHigh) & ~$past(strobe.pullLow)))
        == ($past(strobe.releaseHigh) & ~$past(strobe.pullLow))));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pullLow == '0 && strobe.releaseHigh == '0) |=> $stable(statusQ));

  // R8
  irq_lag_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == ($past(statusQ) != '1));

endmodule

// File: rtl/netirq_agg.sv
module netirq_agg
  import netirq_pkg::*;
#(
  parameter int NUM_SLOTS = 2,
  parameter int SLOT_W = 2,
  parameter int PORT_W = 5,
  parameter int ADDR_W = 8,
  parameter int BASE_ADDR = 'h26,
  parameter int ADDR_STRIDE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setValid,
  input  logic [SLOT_W-1:0] setSlot,
  input  logic [PORT_W-1:0] setPort,
  input  logic              clrValid,
  input  logic [SLOT_W-1:0] clrSlot,
  input  logic [PORT_W-1:0] clrPort,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [STAT_W-1:0] rdData,
  output logic              irqOut
);

  strobe_t strobe;

  netirq_ctrl #(
    .NUM_SLOTS(NUM_SLOTS),
    .SLOT_W(SLOT_W),
    .PORT_W(PORT_W)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .setValid(setValid),
    .setSlot(setSlot),
    .setPort(setPort),
    .clrValid(clrValid),
    .clrSlot(clrSlot),
    .clrPort(clrPort),
    .strobe(strobe)
  );

  netirq_dp #(
    .ADDR_W(ADDR_W),
    .BASE_ADDR(BASE_ADDR),
    .ADDR_STRIDE(ADDR_STRIDE)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .rdAddr(rdAddr),
    .rdData(rdData),
    .irqOut(irqOut)
  );

endmodule

// File: tb/netirq_agg_tb.sv
module netirq_agg_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        setValid = 1'b0;
  logic [1:0]  setSlot = '0;
  logic [4:0]  setPort = '0;
  logic        clrValid = 1'b0;
  logic [1:0]  clrSlot = '0;
  logic [4:0]  clrPort = '0;
  logic [7:0]  rdAddr = 8'h26;
  logic [15:0] rdData;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [15:0] e0;
    logic [15:0] e1;
    logic        eIrq;
    string       tag;
  } item_t;

  item_t q[$];
  logic [15:0] model[2];

  always #(CLK_PERIOD / 2) clk = ~clk;

  netirq_agg u_dut (
    .clk(clk), .rstN(rstN),
    .setValid(setValid), .setSlot(setSlot), .setPort(setPort),
    .clrValid(clrValid), .clrSlot(clrSlot), .clrPort(clrPort),
    .rdAddr(rdAddr), .rdData(rdData), .irqOut(irqOut)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of pulses and pushes the expected result
  task automatic req(bit sv, int ss, int sp, bit cv, int cs, int cp, string tag);
    logic prevAny;
    @(negedge clk);
    setValid = sv; setSlot = 2'(ss); setPort = 5'(sp);
    clrValid = cv; clrSlot = 2'(cs); clrPort = 5'(cp);
    @(posedge clk);
    prevAny = (model[0] != 16'hFFFF) || (model[1] != 16'hFFFF);
    if (cv && cs < 2 && cp < 16) model[cs][cp] = 1'b1;
    if (sv && ss < 2 && sp < 16) model[ss][sp] = 1'b0;
    q.push_back('{model[0], model[1], prevAny, tag});
    #1;
    setValid = 1'b0; clrValid = 1'b0;
  endtask

  // Monitor: pops expected items and compares via the read port
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        it = q.pop_front();
        rdAddr = 8'h26; #1;
        chk({it.tag, " word0"}, rdData, it.e0);
        rdAddr = 8'h28; #1;
        chk({it.tag, " word1"}, rdData, it.e1);
        chk({it.tag, " irq"}, {15'd0, irqOut}, {15'd0, it.eIrq});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model[0] = 16'hFFFF;
    model[1] = 16'hFFFF;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    rdAddr = 8'h26; #1; chk("R1 word0", rdData, 16'hFFFF);
    rdAddr = 8'h28; #1; chk("R1 word1", rdData, 16'hFFFF);
    chk("R1 irq", {15'd0, irqOut}, 16'h0000);
    // R9 unmapped address
    rdAddr = 8'h27; #1; chk("R9 unmapped", rdData, 16'h0000);
    rdAddr = 8'h26;
    @(negedge clk); rstN = 1'b1;

    req(1, 0, 3, 0, 0, 0, "R2 slot0 port3");
    req(0, 0, 0, 0, 0, 0, "R8 irq rises");
    req(1, 1, 15, 0, 0, 0, "R2 slot1 port15");
    req(0, 0, 0, 0, 0, 0, "R10 hold");
    req(0, 0, 0, 1, 0, 3, "R3 drop slot0 port3");
    req(1, 1, 0, 1, 1, 0, "R4 same bit");
    req(1, 0, 5, 1, 1, 15, "R5 two bits");
    req(1, 2, 1, 0, 0, 0, "R6 slot2");
    req(1, 3, 4, 1, 3, 0, "R6 slot3");
    req(1, 0, 16, 0, 0, 0, "R7 port16");
    req(1, 1, 31, 1, 0, 20, "R7 port31");
    req(0, 0, 0, 1, 0, 5, "R3 drop slot0 port5");
    req(0, 0, 0, 1, 1, 0, "R3 drop slot1 port0");
    req(0, 0, 0, 0, 0, 0, "R8 irq falls");
    req(0, 0, 0, 0, 0, 0, "R10 idle");
    repeat (3) @(posedge clk);
    @(negedge clk); #3;
    rdAddr = 8'h2A; #1; chk("R9 unmapped high", rdData, 16'h0000);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule